// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. For every lookup it consults two predictors. The first is a per-branch predictor: the fetch address selects a private history of that branch's recent outcomes, and that history then selects a saturating counter. The second is a path predictor: a register of the most recent outcomes across all branches selects a counter from its own table. A chooser table, indexed by the same global outcome register, decides which of the two answers is used. The prediction is combinational from the lookup address, so fetch can redirect in the same cycle.

Each lookup returns a snapshot of the two histories it used. The pipeline carries that snapshot to branch resolution and presents it again with the real outcome. The predictor then trains both counter tables, the chooser and the per-branch history at the snapshot indices. The global outcome register is advanced speculatively with each prediction. A resolution flagged as mispredicted rebuilds it from the snapshot plus the real outcome.

Top module: `tourney_pred`

## Requirements
- R1: After a synchronous reset the predictor answers not-taken for every address, and both snapshot outputs read zero.
- R2: `predTaken`, `snapGhist` and `snapLhist` are valid in the same cycle as `lookupPc`. `snapLhist` is the per-branch history entry selected by `lookupPc[11:2]`, and `snapGhist` is the global register value before this lookup's update.
- R3: A lookup without a simultaneous mispredict shifts the predicted direction into bit 0 of the global register, discarding its top bit. Cycles with no lookup and no mispredict leave the register unchanged.
- R4: A resolution with `resMispredict` high loads the global register with `{resGhist[10:0], resTaken}`. This has priority over a lookup shift in the same cycle.
- R5: Every resolution shifts `resTaken` into bit 0 of the per-branch history entry selected by `resPc[11:2]`.
- R6: Per-branch counters are 3 bits wide and saturate at 0 and 7. They are incremented on a taken resolution and decremented on a not-taken one, at index `resLhist`. Their predicted direction is bit 2.
- R7: Global counters are 2 bits wide and saturate at 0 and 3. They are trained at index `resGhist` in the same way, and their direction is bit 1.
- R8: Chooser counters are 2 bits wide and are indexed by the global register. Bit 1 set selects the per-branch answer, and bit 1 clear selects the global answer. A chooser counter is trained at `resGhist` only when the two counters read at the snapshot indices disagree, and it moves toward the one that matched `resTaken`.
- R9: Reset loads every per-branch counter with 3, every global counter with 1 and every chooser counter with 1. It also clears all histories. A resolution without mispredict does not alter the global register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookupValid | input | 1 | A branch is being predicted this cycle |
| lookupPc | input | 32 | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| snapGhist | output | 12 | Global outcome register used by this lookup |
| snapLhist | output | 10 | Per-branch history used by this lookup |
| resValid | input | 1 | A branch outcome is being reported |
| resPc | input | 32 | Address of the resolved branch |
| resTaken | input | 1 | Real direction of the resolved branch |
| resMispredict | input | 1 | The resolved branch was mispredicted |
| resGhist | input | 12 | Global snapshot captured at that branch's lookup |
| resLhist | input | 10 | Per-branch snapshot captured at that branch's lookup |

## Verification
A speculative shift of the global register by a new lookup and its repair by a mispredicted resolution can land on the same clock edge. The bench issues a lookup and a mispredicted resolution in one cycle. It then reads the snapshot of the following lookup, which must equal the repaired value and not the shifted one. The chooser and the counter saturation limits are judged only at the ports. The bench steers the global register onto a chosen index and checks which component's direction appears on `predTaken`.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic ghShift;    // speculative shift of the predicted direction
    logic ghRestore;  // rebuild global register from snapshot
    logic train;      // update histories and counters at resolve
    logic trainCh;    // components disagreed: update chooser
    logic chUp;       // chooser moves toward the per-branch side
    logic outcome;    // real direction of the resolved branch
  } tourney_strobe_t;

endpackage

// File: rtl/tourney_ctr_table.sv
module tourney_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rdIdxA,
  output logic             rdMsbA,
  input  logic [IDX_W-1:0] rdIdxB,
  output logic             rdMsbB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUp
);
  localparam int N = 1 << IDX_W;
  localparam logic [CTR_W-1:0] MAXV = '1;
  localparam logic [CTR_W-1:0] INITV = CTR_W'(INIT);

  logic [CTR_W-1:0] mem [N];
  logic [CTR_W-1:0] curW;
  logic [CTR_W-1:0] nextW;

  assign rdMsbA = mem[rdIdxA][CTR_W-1];
  assign rdMsbB = mem[rdIdxB][CTR_W-1];

  always_comb begin
    curW = mem[wrIdx];
    if (wrUp) nextW = (curW == MAXV) ? curW : curW + 1'b1;
    else      nextW = (curW == '0)   ? curW : curW - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mem <= '{default: INITV};
    else if (wrEn) mem[wrIdx] <= nextW;
  end
endmodule

// File: rtl/tourney_ctrl.sv
module tourney_ctrl
  import tourney_pkg::*;
(
  input  logic            lookupValid,
  input  logic            resValid,
  input  logic            resMispredict,
  input  logic            resTaken,
  input  logic            localPred,
  input  logic            globalPred,
  input  logic            useLocal,
  input  logic            resLocalPred,
  input  logic            resGlobalPred,
  output logic            predTaken,
  output tourney_strobe_t strobes
);
  always_comb begin
    predTaken         = useLocal ? localPred : globalPred;
    strobes.ghRestore = resValid && resMispredict;
    strobes.ghShift   = lookupValid && !strobes.ghRestore;
    strobes.train     = resValid;
    strobes.trainCh   = resValid && (resLocalPred != resGlobalPred);
    strobes.chUp      = (resLocalPred == resTaken);
    strobes.outcome   = resTaken;
  end
endmodule

// File: rtl/tourney_dpath.sv
module tourney_dpath
  import tourney_pkg::*;
#(
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int GH_W      = 12,
  parameter int LCTR_W    = 3,
  parameter int GCTR_W    = 2,
  parameter int CH_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LHT_IDX_W-1:0] lookupIdx,
  input  logic [LHT_IDX_W-1:0] resIdx,
  input  logic [GH_W-1:0]      resGhist,
  input  logic [LH_W-1:0]      resLhist,
  input  logic                 predTaken,
  input  tourney_strobe_t      strobes,
  output logic [GH_W-1:0]      ghist,
  output logic [LH_W-1:0]      lhistRd,
  output logic                 localPred,
  output logic                 globalPred,
  output logic                 useLocal,
  output logic                 resLocalPred,
  output logic                 resGlobalPred
);
  localparam int LHT_N    = 1 << LHT_IDX_W;
  localparam int LINIT    = (1 << (LCTR_W - 1)) - 1;
  localparam int GINIT    = (1 << (GCTR_W - 1)) - 1;
  localparam int CINIT    = (1 << (CH_W - 1)) - 1;

  logic [LH_W-1:0] lht [LHT_N];
  logic            chResUnused;

  assign lhistRd = lht[lookupIdx];

  // Per-branch history table: shifts in the real outcome at resolve.
  always_ff @(posedge clk) begin
    if (rst) lht <= '{default: '0};
    else if (strobes.train)
      lht[resIdx] <= {lht[resIdx][LH_W-2:0], strobes.outcome};
  end

  // Global outcome register: repair wins over speculative shift.
  always_ff @(posedge clk) begin
    if (rst) ghist <= '0;
    else if (strobes.ghRestore) ghist <= {resGhist[GH_W-2:0], strobes.outcome};
    else if (strobes.ghShift)   ghist <= {ghist[GH_W-2:0], predTaken};
  end

  tourney_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W), .INIT(LINIT)) u_localCtr (
    .clk(clk), .rst(rst),
    .rdIdxA(lhistRd), .rdMsbA(localPred),
    .rdIdxB(resLhist), .rdMsbB(resLocalPred),
    .wrEn(strobes.train), .wrIdx(resLhist), .wrUp(strobes.outcome)
  );

  tourney_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W), .INIT(GINIT)) u_globalCtr (
    .clk(clk), .rst(rst),
    .rdIdxA(ghist), .rdMsbA(globalPred),
    .rdIdxB(resGhist), .rdMsbB(resGlobalPred),
    .wrEn(strobes.train), .wrIdx(resGhist), .wrUp(strobes.outcome)
  );

  tourney_ctr_table #(.IDX_W(GH_W), .CTR_W(CH_W), .INIT(CINIT)) u_chooser (
    .clk(clk), .rst(rst),
    .rdIdxA(ghist), .rdMsbA(useLocal),
    .rdIdxB(resGhist), .rdMsbB(chResUnused),
    .wrEn(strobes.trainCh), .wrIdx(resGhist), .wrUp(strobes.chUp)
  );
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tourney_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int GH_W      = 12,
  parameter int LCTR_W    = 3,
  parameter int GCTR_W    = 2,
  parameter int CH_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lookupValid,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  output logic [GH_W-1:0] snapGhist,
  output logic [LH_W-1:0] snapLhist,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic            resMispredict,
  input  logic [GH_W-1:0] resGhist,
  input  logic [LH_W-1:0] resLhist
);
  localparam int IDX_HI = LHT_IDX_W + 1;

  tourney_strobe_t strobes;
  logic localPred, globalPred, useLocal, resLocalPred, resGlobalPred;
  logic unusedPcBits;

  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[1:0],
                          resPc[PC_W-1:IDX_HI+1], resPc[1:0]};

  tourney_ctrl u_ctrl (
    .lookupValid(lookupValid), .resValid(resValid),
    .resMispredict(resMispredict), .resTaken(resTaken),
    .localPred(localPred), .globalPred(globalPred), .useLocal(useLocal),
    .resLocalPred(resLocalPred), .resGlobalPred(resGlobalPred),
    .predTaken(predTaken), .strobes(strobes)
  );

  tourney_dpath #(
    .LHT_IDX_W(LHT_IDX_W), .LH_W(LH_W), .GH_W(GH_W),
    .LCTR_W(LCTR_W), .GCTR_W(GCTR_W), .CH_W(CH_W)
  ) u_dpath (
    .clk(clk), .rst(rst),
    .lookupIdx(lookupPc[IDX_HI:2]), .resIdx(resPc[IDX_HI:2]),
    .resGhist(resGhist), .resLhist(resLhist),
    .predTaken(predTaken), .strobes(strobes),
    .ghist(snapGhist), .lhistRd(snapLhist),
    .localPred(localPred), .globalPred(globalPred), .useLocal(useLocal),
    .resLocalPred(resLocalPred), .resGlobalPred(resGlobalPred)
  );
endmodule

// File: rtl/tourney_chk.sv
module tourney_chk #(
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lookupValid,
  input logic            predTaken,
  input logic [GH_W-1:0] snapGhist,
  input logic            resValid,
  input logic            resMispredict,
  input logic            resTaken,
  input logic [GH_W-1:0] resGhist
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (snapGhist == '0 && !predTaken));

  // R3
  spec_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (lookupValid && !(resValid && resMispredict)) |=>
      snapGhist == {$past(snapGhist[GH_W-2:0]), $past(predTaken)});

  // R4
  repair_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resMispredict) |=>
      snapGhist == {$past(resGhist[GH_W-2:0]), $past(resTaken)});

  // R9
  hold_ghist_chk: assert property (@(posedge clk) disable iff (rst)
    (!lookupValid && !(resValid && resMispredict)) |=> $stable(snapGhist));
endmodule

bind tourney_pred tourney_chk #(.GH_W(GH_W)) u_chk (
  .clk(clk), .rst(rst), .lookupValid(lookupValid), .predTaken(predTaken),
  .snapGhist(snapGhist), .resValid(resValid), .resMispredict(resMispredict),
  .resTaken(resTaken), .resGhist(resGhist)
);

// File: tb/tourney_pred_bench.sv
module tourney_pred_bench;
  logic clk = 0;
  logic rst = 1;
  logic lookupValid = 0;
  logic [31:0] lookupPc = '0;
  logic predTaken;
  logic [11:0] snapGhist;
  logic [9:0] snapLhist;
  logic resValid = 0;
  logic [31:0] resPc = '0;
  logic resTaken = 0;
  logic resMispredict = 0;
  logic [11:0] resGhist = '0;
  logic [9:0] resLhist = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tourney_pred u_tourney_pred (.*);

  typedef struct packed {
    logic lk; logic [31:0] lkPc;
    logic rs; logic [31:0] rsPc; logic rsT; logic rsM;
    logic [11:0] rsG; logic [9:0] rsL;
    logic chk; logic expP; logic [11:0] expG; logic [9:0] expL;
    logic [7:0] req;
  } vec_t;

  localparam logic [31:0] PCP = 32'h100;
  localparam logic [31:0] PCQ = 32'h040;
  localparam logic [31:0] PCR = 32'h080;

  function automatic vec_t mkLk(logic [31:0] pc, logic p, logic [11:0] g,
                                logic [9:0] l, logic [7:0] req);
    vec_t v = '0;
    v.lk = 1; v.lkPc = pc; v.chk = 1; v.expP = p; v.expG = g; v.expL = l; v.req = req;
    return v;
  endfunction

  function automatic vec_t mkRs(logic [31:0] pc, logic t, logic m,
                                logic [11:0] g, logic [9:0] l);
    vec_t v = '0;
    v.rs = 1; v.rsPc = pc; v.rsT = t; v.rsM = m; v.rsG = g; v.rsL = l;
    return v;
  endfunction

  function automatic vec_t mkBoth(vec_t a, vec_t b);
    vec_t v = a;
    v.rs = 1; v.rsPc = b.rsPc; v.rsT = b.rsT; v.rsM = b.rsM; v.rsG = b.rsG; v.rsL = b.rsL;
    return v;
  endfunction

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    mkLk(PCP, 0, 12'h000, 10'h000, 1),          // R1 initial state
    mkRs(PCP, 1, 1, 12'h000, 10'h000),
    mkLk(PCP, 0, 12'h001, 10'h001, 5),          // R5 history took outcome
    mkLk(PCQ, 0, 12'h002, 10'h000, 3),          // R3 shift of a not-taken guess
    mkRs(PCR, 0, 1, 12'h010, 10'h1F4),
    mkRs(PCR, 1, 0, 12'h020, 10'h190),
    mkRs(PCR, 1, 0, 12'h020, 10'h190),
    mkRs(PCR, 1, 0, 12'h020, 10'h190),
    mkLk(PCQ, 1, 12'h020, 10'h000, 7),          // R7 global counter, R9 hold
    mkRs(PCR, 0, 0, 12'h020, 10'h190),
    mkRs(PCR, 0, 1, 12'h010, 10'h1F4),
    mkLk(PCQ, 1, 12'h020, 10'h000, 7),          // R7 saturated at 3
    mkRs(PCR, 0, 0, 12'h020, 10'h190),
    mkRs(PCR, 0, 1, 12'h010, 10'h1F4),
    mkLk(PCQ, 0, 12'h020, 10'h000, 7),          // R7 down to 1
    mkRs(PCQ, 1, 0, 12'h300, 10'h100),
    mkRs(PCQ, 0, 0, 12'h300, 10'h100),
    mkRs(PCQ, 1, 0, 12'h300, 10'h100),
    mkRs(PCR, 1, 0, 12'h008, 10'h005),
    mkRs(PCR, 1, 0, 12'h007, 10'h005),
    mkRs(PCR, 0, 0, 12'h007, 10'h200),
    mkRs(PCR, 1, 1, 12'h003, 10'h210),
    mkLk(PCQ, 1, 12'h007, 10'h005, 8),          // R8 chooser picks per-branch
    mkLk(PCP, 0, 12'h00F, 10'h001, 3),          // R3 shift of a taken guess
    mkBoth(mkLk(PCQ, 0, 12'h01E, 10'h005, 2),   // R2 same-cycle answer
           mkRs(PCR, 1, 1, 12'h003, 10'h210)),
    mkLk(PCQ, 1, 12'h007, 10'h005, 4),          // R4 repair beat the shift
    mkRs(PCR, 1, 0, 12'h300, 10'h005),
    mkRs(PCR, 1, 0, 12'h300, 10'h005),
    mkRs(PCR, 1, 0, 12'h300, 10'h005),
    mkRs(PCR, 0, 0, 12'h301, 10'h005),
    mkRs(PCR, 0, 0, 12'h301, 10'h005),
    mkRs(PCR, 0, 0, 12'h301, 10'h005),
    mkRs(PCR, 1, 1, 12'h003, 10'h210),
    mkLk(PCQ, 1, 12'h007, 10'h005, 6),          // R6 saturated at 7, now 4
    mkRs(PCR, 0, 0, 12'h301, 10'h005),
    mkRs(PCR, 1, 1, 12'h003, 10'h210),
    mkLk(PCQ, 0, 12'h007, 10'h005, 6)           // R6 down to 3
  };

  task automatic check(string what, int req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lookupValid = VECS[i].lk; lookupPc = VECS[i].lkPc;
      resValid = VECS[i].rs; resPc = VECS[i].rsPc; resTaken = VECS[i].rsT;
      resMispredict = VECS[i].rsM; resGhist = VECS[i].rsG; resLhist = VECS[i].rsL;
      #1;
      if (VECS[i].chk) begin
        check("predTaken", int'(VECS[i].req), int'(predTaken), int'(VECS[i].expP));
        check("snapGhist", int'(VECS[i].req), int'(snapGhist), int'(VECS[i].expG));
        check("snapLhist", int'(VECS[i].req), int'(snapLhist), int'(VECS[i].expL));
      end
    end
    // R1 / R9: mid-run reset clears trained state and histories
    @(negedge clk);
    lookupValid = 0; resValid = 0; rst = 1;
    @(negedge clk);
    rst = 0; lookupValid = 1; lookupPc = PCQ;
    #1;
    check("predTaken after reset", 1, int'(predTaken), 0);
    check("snapGhist after reset", 9, int'(snapGhist), 0);
    check("snapLhist after reset", 9, int'(snapLhist), 0);
    @(negedge clk);
    lookupValid = 0;
    @(negedge clk);
    summary();
  end
endmodule